// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block gathers level-sensitive request lines from a set of peripherals and presents one request at a time to a processor. Each line holds a two-bit priority (0 lowest, 3 highest) and a handler vector address. Both sit in registers that can be rewritten at any time through a single write port. A global enable and one enable bit per level gate every line before arbitration. The request shown is the highest-level pending line, and among lines of the same level, the lowest-numbered one.

The processor accepts the offered request with an acknowledge pulse, which records that level as in service. While a level is in service, only a request at a strictly higher level is offered. That request nests on top of the current one. An end-of-service pulse retires the newest level in service and restores the one beneath it. A line is sampled into a register once. Arbitration is purely combinational from registered state, so a line asserted before a clock edge appears on the request outputs right after that edge, and an acknowledge takes effect at the next edge.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset, no request is offered, nothing is in service, the global enable is off, all four level enables are on, and every line has level 0 and vector 0.
- R2: Request lines are level-sensitive. A line sampled high at a clock edge is offered just after that edge. It stops being offered just after the edge that samples it low.
- R3: Among offered candidates, a line at a higher level always wins over a line at a lower level, whatever their indices.
- R4: Among candidates of the same level, the lowest-numbered line wins.
- R5: Writing the control register (wr_sel = 2) sets the global enable from wr_data bit 0. While the global enable is off, no request is offered.
- R6: The control register also holds one enable bit per level: level k uses wr_data bit k+1. A line whose level is disabled does not take part in arbitration.
- R7: A level write (wr_sel = 0, level in wr_data[1:0]) to line wr_idx changes that line's arbitration from the edge that performs the write.
- R8: A vector write (wr_sel = 1) stores wr_data as the handler vector of line wr_idx. req_vec always shows the stored vector of the offered line.
- R9: An acknowledge while a request is offered puts that request's level in service (act_valid high, act_lvl equal to it). After that, only requests at a strictly higher level are offered.
- R10: An end-of-service pulse retires the highest level in service, so a nested service returns to the level it preempted. When the last level retires, act_valid goes low.
- R11: An acknowledge while no request is offered, an end-of-service pulse while nothing is in service, and a write with wr_sel = 3 all have no effect.
- R12: A vector write in the same cycle as the acknowledge of that line does not change the vector that acknowledge took. The new value is presented at the line's next offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NUM_SRC | Level-sensitive request lines |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 level, 1 vector, 2 control, 3 reserved |
| wr_idx | input | IDX_W | Line index for level and vector writes |
| wr_data | input | VEC_W | Write data |
| req_valid | output | 1 | A request is offered to the processor |
| req_src | output | IDX_W | Index of the offered line |
| req_lvl | output | 2 | Level of the offered line |
| req_vec | output | VEC_W | Handler vector of the offered line |
| ack_i | input | 1 | Processor accepts the offered request |
| eos_i | input | 1 | Processor finished the newest service |
| act_valid | output | 1 | At least one level is in service |
| act_lvl | output | 2 | Highest level in service |

## Verification
The lines are raised in a growing set. A lone low-level line is followed by two lines of the same level, then by higher levels with larger indices. This separates ordering by level from ordering by index. The same pending set is then run with a level masked, with a line's level lowered, and with the global enable cleared, to show that each gate acts on its own. A nested pair of acknowledges is made with a vector rewrite landing on the second one, and the retires that follow show the return to the preempted level, the stale vector versus the fresh vector, and that stray handshakes change nothing.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
   localparam int LVL_N = 4;
   localparam int LVL_W = 2;

   typedef logic [LVL_W-1:0] lvl_t;

   typedef enum logic [1:0] {
      SEL_LVL = 2'd0,
      SEL_VEC = 2'd1,
      SEL_CTL = 2'd2,
      SEL_RSV = 2'd3
   } wsel_e;
endpackage

// File: rtl/lvl_irq_cfg.sv
module lvl_irq_cfg
   import lvl_irq_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int VEC_W   = 16,
   parameter int IDX_W   = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [1:0]                    wr_sel,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [VEC_W-1:0]              wr_data,
   output lvl_t [NUM_SRC-1:0]            lvl_tab,
   output logic [NUM_SRC-1:0][VEC_W-1:0] vec_tab,
   output logic                          glb_en,
   output logic [LVL_N-1:0]              lvl_en
);
   wsel_e sel;
   logic  idx_ok;

   assign sel    = wsel_e'(wr_sel);
   assign idx_ok = (int'(wr_idx) < NUM_SRC);

   // per-line level and vector storage
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
      logic hit;
      assign hit = wr_en && idx_ok && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lvl_tab[i] <= '0;
            vec_tab[i] <= '0;
         end else begin
            if (hit && sel == SEL_LVL) lvl_tab[i] <= wr_data[LVL_W-1:0];
            if (hit && sel == SEL_VEC) vec_tab[i] <= wr_data;
         end
      end
   end

   // control register: global enable and per-level enables
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glb_en <= 1'b0;
         lvl_en <= '1;
      end else if (wr_en && sel == SEL_CTL) begin
         glb_en <= wr_data[0];
         lvl_en <= wr_data[LVL_N:1];
      end
   end

   // R11
   rsv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_RSV) |=> ($stable(lvl_tab) && $stable(vec_tab)
                                    && $stable(glb_en) && $stable(lvl_en)));
endmodule

// File: rtl/lvl_irq_arb.sv
module lvl_irq_arb
   import lvl_irq_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int VEC_W   = 16,
   parameter int IDX_W   = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_SRC-1:0]            pend,
   input  lvl_t [NUM_SRC-1:0]            lvl_tab,
   input  logic [NUM_SRC-1:0][VEC_W-1:0] vec_tab,
   input  logic                          glb_en,
   input  logic [LVL_N-1:0]              lvl_en,
   input  logic                          act_any,
   input  lvl_t                          act_top,
   output logic                          req_valid,
   output logic [IDX_W-1:0]              req_src,
   output lvl_t                          req_lvl,
   output logic [VEC_W-1:0]              req_vec
);
   logic [NUM_SRC-1:0]          gated;
   logic [LVL_N-1:0]            lvl_any;
   logic [LVL_N-1:0][IDX_W-1:0] lvl_idx;
   logic                        best_any;
   lvl_t                        best_lvl;
   logic [IDX_W-1:0]            best_idx;

   // gating before arbitration
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
      assign gated[i] = pend[i] && glb_en && lvl_en[lvl_tab[i]];
   end

   // one lowest-index finder per level, all in parallel
   for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
      logic [NUM_SRC-1:0] hit;
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
         assign hit[i] = gated[i] && (lvl_tab[i] == lvl_t'(l));
      end
      always_comb begin
         lvl_idx[l] = '0;
         for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (hit[i]) lvl_idx[l] = IDX_W'(i);
         end
      end
      assign lvl_any[l] = |hit;
   end

   // highest non-empty level wins
   always_comb begin
      best_any = 1'b0;
      best_lvl = '0;
      best_idx = '0;
      for (int l = 0; l < LVL_N; l++) begin
         if (lvl_any[l]) begin
            best_any = 1'b1;
            best_lvl = lvl_t'(l);
            best_idx = lvl_idx[l];
         end
      end
   end

   assign req_valid = best_any && (!act_any || (best_lvl > act_top));
   assign req_src   = best_idx;
   assign req_lvl   = best_lvl;
   assign req_vec   = vec_tab[best_idx];

   // R2
   offer_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> pend[req_src]);
   // R3
   no_higher_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (lvl_tab[req_src] == req_lvl));
endmodule

// File: rtl/lvl_irq_nest.sv
module lvl_irq_nest
   import lvl_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ack_i,
   input  logic eos_i,
   input  logic req_valid,
   input  lvl_t req_lvl,
   output logic act_any,
   output lvl_t act_top
);
   // in-service levels grow strictly, so a bit per level holds the stack
   logic [LVL_N-1:0] act_set;
   logic [LVL_N-1:0] act_nxt;
   logic             push;
   logic             pop;

   always_comb begin
      act_top = '0;
      for (int l = 0; l < LVL_N; l++) begin
         if (act_set[l]) act_top = lvl_t'(l);
      end
   end
   assign act_any = |act_set;

   assign push = ack_i && req_valid;
   assign pop  = eos_i && act_any;

   always_comb begin
      act_nxt = act_set;
      if (pop)  act_nxt[act_top] = 1'b0;
      if (push) act_nxt[req_lvl] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) act_set <= '0;
      else        act_set <= act_nxt;
   end

   // R9
   push_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !eos_i) |=> (act_any && act_top == $past(req_lvl)));
   // R10
   pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !ack_i) |=> ($countones(act_set) == $countones($past(act_set)) - 1));
   // R11
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && !pop) |=> $stable(act_set));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
   import lvl_irq_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int VEC_W   = 16,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_i,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [VEC_W-1:0]   wr_data,
   output logic               req_valid,
   output logic [IDX_W-1:0]   req_src,
   output logic [1:0]         req_lvl,
   output logic [VEC_W-1:0]   req_vec,
   input  logic               ack_i,
   input  logic               eos_i,
   output logic               act_valid,
   output logic [1:0]         act_lvl
);
   if (NUM_SRC < 2) begin : g_bad_src
      $error("lvl_irq_ctrl: NUM_SRC must be at least 2");
   end
   if (VEC_W < LVL_N + 1) begin : g_bad_vec
      $error("lvl_irq_ctrl: VEC_W too narrow for the control word");
   end

   logic [NUM_SRC-1:0]            irq_q;
   lvl_t [NUM_SRC-1:0]            lvl_tab;
   logic [NUM_SRC-1:0][VEC_W-1:0] vec_tab;
   logic                          glb_en;
   logic [LVL_N-1:0]              lvl_en;
   logic                          act_any;
   lvl_t                          act_top;
   lvl_t                          req_lvl_w;

   // single sampling stage for the request lines
   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= irq_i;
   end

   lvl_irq_cfg #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .IDX_W(IDX_W)) cfg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .lvl_tab (lvl_tab),
      .vec_tab (vec_tab),
      .glb_en  (glb_en),
      .lvl_en  (lvl_en)
   );

   lvl_irq_arb #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .IDX_W(IDX_W)) arb_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend      (irq_q),
      .lvl_tab   (lvl_tab),
      .vec_tab   (vec_tab),
      .glb_en    (glb_en),
      .lvl_en    (lvl_en),
      .act_any   (act_any),
      .act_top   (act_top),
      .req_valid (req_valid),
      .req_src   (req_src),
      .req_lvl   (req_lvl_w),
      .req_vec   (req_vec)
   );

   lvl_irq_nest nest_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ack_i     (ack_i),
      .eos_i     (eos_i),
      .req_valid (req_valid),
      .req_lvl   (req_lvl_w),
      .act_any   (act_any),
      .act_top   (act_top)
   );

   assign req_lvl   = req_lvl_w;
   assign act_valid = act_any;
   assign act_lvl   = act_top;

   // R9
   strict_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && act_valid) |-> (req_lvl > act_lvl));
   // R5
   glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> !req_valid);
   // R6
   masked_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> lvl_en[req_lvl]);
endmodule

// File: tb/lvl_irq_ctrl_tb.sv
module lvl_irq_ctrl_tb_top;
   localparam int CLK_P = 10;
   localparam int N     = 8;
   localparam int VW    = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_i = '0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = '0;
   logic [2:0]    wr_idx = '0;
   logic [VW-1:0] wr_data = '0;
   logic          ack_i = 1'b0;
   logic          eos_i = 1'b0;
   logic          req_valid;
   logic [2:0]    req_src;
   logic [1:0]    req_lvl;
   logic [VW-1:0] req_vec;
   logic          act_valid;
   logic [1:0]    act_lvl;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   lvl_irq_ctrl #(.NUM_SRC(N), .VEC_W(VW)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
      .req_valid(req_valid), .req_src(req_src), .req_lvl(req_lvl), .req_vec(req_vec),
      .ack_i(ack_i), .eos_i(eos_i), .act_valid(act_valid), .act_lvl(act_lvl)
   );

   typedef struct {
      bit    vld;
      int    src;
      int    lvl;
      int    vec;
      bit    av;
      int    al;
      string tag;
   } exp_t;

   exp_t sb_q[$];

   function automatic int vec_of(input int i);
      return 32'h1000 + i * 16;
   endfunction

   task automatic fail_line(input string tag, input string what, input int act, input int exp);
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
   endtask

   // monitor: compare one expected item per falling edge
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_vec++;
            if (req_valid !== e.vld) fail_line(e.tag, "req_valid", int'(req_valid), int'(e.vld));
            else if (e.vld) begin
               if (int'(req_src) != e.src) fail_line(e.tag, "req_src", int'(req_src), e.src);
               if (int'(req_lvl) != e.lvl) fail_line(e.tag, "req_lvl", int'(req_lvl), e.lvl);
               if (int'(req_vec) != e.vec) fail_line(e.tag, "req_vec", int'(req_vec), e.vec);
            end
            if (act_valid !== e.av) fail_line(e.tag, "act_valid", int'(act_valid), int'(e.av));
            else if (e.av && int'(act_lvl) != e.al)
               fail_line(e.tag, "act_lvl", int'(act_lvl), e.al);
         end
      end
   end

   // driver: one clock edge, push expectation, release pulses
   task automatic step(input bit vld, input int src, input int lvl, input int vec,
                       input bit av, input int al, input string tag);
      exp_t e;
      @(posedge clk);
      e.vld = vld; e.src = src; e.lvl = lvl; e.vec = vec;
      e.av = av; e.al = al; e.tag = tag;
      sb_q.push_back(e);
      #2;
      wr_en = 1'b0;
      ack_i = 1'b0;
      eos_i = 1'b0;
   endtask

   task automatic wr(input int sel, input int idx, input int data);
      wr_en   = 1'b1;
      wr_sel  = 2'(sel);
      wr_idx  = 3'(idx);
      wr_data = VW'(data);
   endtask

   initial begin
      int lv[N];
      lv = '{0, 1, 2, 3, 1, 2, 0, 3};
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      step(0, 0, 0, 0, 0, 0, "R1");
      irq_i = '1;
      step(0, 0, 0, 0, 0, 0, "R1");
      step(0, 0, 0, 0, 0, 0, "R5");
      irq_i = '0;
      for (int i = 0; i < N; i++) begin
         wr(0, i, lv[i]);
         step(0, 0, 0, 0, 0, 0, "R7");
         wr(1, i, vec_of(i));
         step(0, 0, 0, 0, 0, 0, "R8");
      end
      wr(2, 0, 'h1F);
      step(0, 0, 0, 0, 0, 0, "R5");
      irq_i = 8'h40;
      step(1, 6, 0, vec_of(6), 0, 0, "R2");
      irq_i = 8'h52;
      step(1, 1, 1, vec_of(1), 0, 0, "R4");
      irq_i = 8'h76;
      step(1, 2, 2, vec_of(2), 0, 0, "R4");
      irq_i = 8'hF6;
      step(1, 7, 3, vec_of(7), 0, 0, "R3");
      wr(2, 0, 'h0F);
      step(1, 2, 2, vec_of(2), 0, 0, "R6");
      wr(2, 0, 'h1F);
      step(1, 7, 3, vec_of(7), 0, 0, "R6");
      wr(0, 7, 0);
      step(1, 2, 2, vec_of(2), 0, 0, "R7");
      ack_i = 1'b1;
      step(0, 0, 0, 0, 1, 2, "R9");
      wr(0, 6, 2);
      step(0, 0, 0, 0, 1, 2, "R9");
      wr(0, 6, 3);
      step(1, 6, 3, vec_of(6), 1, 2, "R9");
      ack_i = 1'b1;
      wr(1, 6, 'hBEEF);
      step(0, 0, 0, 0, 1, 3, "R12");
      eos_i = 1'b1;
      step(1, 6, 3, 'hBEEF, 1, 2, "R10");
      eos_i = 1'b1;
      step(1, 6, 3, 'hBEEF, 0, 0, "R12");
      eos_i = 1'b1;
      step(1, 6, 3, 'hBEEF, 0, 0, "R11");
      irq_i = 8'h02;
      step(1, 1, 1, vec_of(1), 0, 0, "R2");
      irq_i = 8'h00;
      step(0, 0, 0, 0, 0, 0, "R2");
      ack_i = 1'b1;
      step(0, 0, 0, 0, 0, 0, "R11");
      irq_i = 8'h08;
      step(1, 3, 3, vec_of(3), 0, 0, "R2");
      wr(3, 3, 0);
      step(1, 3, 3, vec_of(3), 0, 0, "R11");
      wr(2, 0, 'h00);
      step(0, 0, 0, 0, 0, 0, "R5");
      @(negedge clk);
      #1;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 5000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end
endmodule